// File: doc/BRIEF.md
# 64-bit Substitution-Permutation Block Encryptor with Rolling 128-bit Key

This block encrypts one 64-bit data word under a 128-bit key. It runs a lightweight substitution-permutation network of 31 rounds and computes one round per clock. Each round mixes a round key into the state, passes every nibble through a fixed 4-bit substitution table and then scatters the bits through a fixed wiring permutation. The round key is never stored as a list. A single 128-bit key register is transformed in place on every round, so it always holds the key needed next.

A caller raises `start` for one cycle with the plaintext and key present. The block captures both, runs 31 rounds and then pulses `done` for one cycle. The output word is the state after round 31 combined with the 32nd round key. It stays on `ciphertext` until the next accepted start. A start that arrives while a block is in flight is ignored.

Top module: `spn_cipher64`

## Requirements
- R1: After reset `done` is 0 and `ciphertext` is all zeros.
- R2: A start sampled high while idle captures `plaintext` and `key`. `done` is then high for exactly one cycle, in the cycle that follows the 31st rising edge after the capturing edge.
- R3: Each round XORs the state with key register bits [127:64]. It replaces every nibble v with entry v of the table C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2 (input 0..F). It then moves bit i to position 16*i mod 63 for i < 63, and bit 63 stays at position 63.
- R4: After each round the key register is rotated left by 61 bits. Next, nibbles [127:124] and [123:120] pass through the same table. Then the round number, which is 1 in the first round and 31 in the last, is XORed into bits [66:62].
- R5: `ciphertext` equals the state after 31 rounds XORed with bits [127:64] of the key register after 31 updates. An all-zero plaintext under an all-zero key gives 64'h96db702a2e6900af.
- R6: A start that arrives while a block is in flight is ignored. The running block finishes on time with its own result.
- R7: Once `done` has pulsed, `ciphertext` holds its value until the next accepted start.
- R8: A start in the same cycle in which `done` is high is accepted as a new block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a block; sampled on the rising edge |
| plaintext | input | 64 | Data word to encrypt, captured with start |
| key | input | 128 | Cipher key, captured with start |
| ciphertext | output | 64 | Encrypted word, valid from done until the next start |
| done | output | 1 | One-cycle pulse when ciphertext is valid |

## Verification
On every cycle the assertions track the block's timing. They follow the internal round number against an independent count from the accepted start, they place the `done` pulse exactly 31 edges after capture and keep it one cycle wide, and they hold `ciphertext` steady while the block is idle. Whether the rounds compute the right value (the substitution table, the bit scatter, the key rotation with its counter injection and the final key addition) can only be shown by the bench's scenarios. There, a behavioural model and the published all-zero vector are compared against the output. The bench scenarios also cover ignored mid-run starts and back-to-back blocks.

// File: rtl/spn_cipher64.sv
module spn_cipher64 (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [63:0]  plaintext,
  input  logic [127:0] key,
  output logic [63:0]  ciphertext,
  output logic         done
);
  localparam int NIB    = 16;
  localparam int LAST   = 31;
  localparam int RW     = 5;

  function automatic logic [3:0] sub4(input logic [3:0] v);
    case (v)
      4'h0: sub4 = 4'hC; 4'h1: sub4 = 4'h5; 4'h2: sub4 = 4'h6; 4'h3: sub4 = 4'hB;
      4'h4: sub4 = 4'h9; 4'h5: sub4 = 4'h0; 4'h6: sub4 = 4'hA; 4'h7: sub4 = 4'hD;
      4'h8: sub4 = 4'h3; 4'h9: sub4 = 4'hE; 4'hA: sub4 = 4'hF; 4'hB: sub4 = 4'h8;
      4'hC: sub4 = 4'h4; 4'hD: sub4 = 4'h7; 4'hE: sub4 = 4'h1; default: sub4 = 4'h2;
    endcase
  endfunction

  logic          busy;
  logic [RW-1:0] rnd;
  logic [63:0]   st;
  logic [127:0]  kr;
  logic          done_q;

  logic [63:0]   mixed, subbed, permuted;
  logic [127:0]  krot, knext;

  assign mixed = st ^ kr[127:64];

  for (genvar n = 0; n < NIB; n++) begin : g_sbox
    assign subbed[4*n +: 4] = sub4(mixed[4*n +: 4]);
  end

  for (genvar b = 0; b < 63; b++) begin : g_perm
    assign permuted[(16*b) % 63] = subbed[b];
  end
  assign permuted[63] = subbed[63];

  assign krot  = {kr[66:0], kr[127:67]};
  assign knext = {sub4(krot[127:124]), sub4(krot[123:120]), krot[119:67],
                  krot[66:62] ^ rnd, krot[61:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      rnd    <= '0;
      st     <= '0;
      kr     <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy) begin
        st   <= plaintext;
        kr   <= key;
        rnd  <= RW'(1);
        busy <= 1'b1;
      end else if (busy) begin
        st  <= permuted;
        kr  <= knext;
        rnd <= rnd + RW'(1);
        if (rnd == RW'(LAST)) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign ciphertext = st ^ kr[127:64];
  assign done       = done_q;
endmodule

module spn_cipher64_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        done,
  input logic [63:0] ciphertext,
  input logic [4:0]  rnd
);
  logic       act;
  logic [4:0] cnt;
  logic       last;

  assign last = act && (cnt == 5'd31);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act <= 1'b0;
      cnt <= '0;
    end else if (!act && start) begin
      act <= 1'b1;
      cnt <= 5'd1;
    end else if (act) begin
      cnt <= cnt + 5'd1;
      if (cnt == 5'd31) act <= 1'b0;
    end
  end

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_timing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> done);

  p_no_early_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !last |=> !done);

  p_round_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> (rnd == cnt));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!act && !start) |=> $stable(ciphertext));
endmodule

bind spn_cipher64 spn_cipher64_chk chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done),
  .ciphertext(ciphertext), .rnd(rnd)
);

// File: tb/spn_cipher64_test.sv
module spn_cipher64_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [63:0]  plaintext = '0;
  logic [127:0] key = '0;
  logic [63:0]  ciphertext;
  logic         done;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic [63:0] last_ct;

  typedef struct { logic [63:0] ct; int due; } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spn_cipher64 uut (.*);

  localparam logic [3:0] TBL [16] = '{4'hC, 4'h5, 4'h6, 4'hB, 4'h9, 4'h0, 4'hA, 4'hD,
                                      4'h3, 4'hE, 4'hF, 4'h8, 4'h4, 4'h7, 4'h1, 4'h2};

  function automatic logic [63:0] model(input logic [63:0] p, input logic [127:0] k);
    logic [63:0] s, t;
    logic [127:0] kk;
    s = p; kk = k;
    for (int r = 1; r <= 31; r++) begin
      s = s ^ kk[127:64];
      for (int n = 0; n < 16; n++) s[4*n +: 4] = TBL[s[4*n +: 4]];
      for (int i = 0; i < 64; i++) t[(i % 4) * 16 + i / 4] = s[i];
      s = t;
      kk = {kk[66:0], kk[127:67]};
      kk[127:124] = TBL[kk[127:124]];
      kk[123:120] = TBL[kk[123:120]];
      kk[66:62] = kk[66:62] ^ 5'(r);
    end
    return s ^ kk[127:64];
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; returns one cycle after the capturing edge
  task automatic encrypt(input logic [63:0] p, input logic [127:0] k, input logic [63:0] exp);
    exp_t e;
    start = 1'b1; plaintext = p; key = k;
    @(posedge clk); #1;
    e.ct = exp; e.due = cyc + 31;
    q.push_back(e);
    start = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      if (done) begin
        exp_t e;
        e = q.pop_front();
        check(ciphertext == e.ct, "R3/R4/R5 ciphertext", ciphertext, e.ct);
        check(cyc == e.due, "R2 done latency", 64'(cyc), 64'(e.due));
        last_ct = ciphertext;
      end else if (q[0].due == cyc) begin
        check(1'b0, "R2 done missing", 64'(done), 64'd1);
        void'(q.pop_front());
      end
    end else if (rst_n && done) begin
      check(1'b0, "R2 unexpected done", 64'(done), 64'd0);
    end
  end

  initial begin
    #80000;
    check(1'b0, "watchdog", 64'(cyc), 64'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 done after reset", 64'(done), 64'd0);
    check(ciphertext == 64'd0, "R1 ciphertext after reset", ciphertext, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    encrypt(64'd0, 128'd0, 64'h96db702a2e6900af);
    wait_done();
    check(ciphertext == 64'h96db702a2e6900af, "R5 published vector", ciphertext, 64'h96db702a2e6900af);
    @(negedge clk);
    check(done == 1'b0, "R2 done one cycle", 64'(done), 64'd0);

    @(negedge clk);
    encrypt(64'hffff_ffff_ffff_ffff, 128'd0, model(64'hffff_ffff_ffff_ffff, 128'd0));
    wait_done();
    repeat (5) @(negedge clk);
    check(ciphertext == last_ct, "R7 ciphertext held", ciphertext, last_ct);

    encrypt(64'h0123_4567_89ab_cdef, 128'h0011_2233_4455_6677_8899_aabb_ccdd_eeff,
            model(64'h0123_4567_89ab_cdef, 128'h0011_2233_4455_6677_8899_aabb_ccdd_eeff));
    repeat (10) @(negedge clk);
    // R6: mid-run start with other data must be ignored
    start = 1'b1; plaintext = 64'hdead_beef_0000_1111; key = {128{1'b1}};
    @(negedge clk);
    start = 1'b0;
    wait_done();

    // R8: start in the done cycle is accepted
    encrypt(64'd0, {128{1'b1}}, model(64'd0, {128{1'b1}}));
    wait_done();
    encrypt(64'hfedc_ba98_7654_3210, 128'h8000_0000_0000_0000_0000_0000_0000_0001,
            model(64'hfedc_ba98_7654_3210, 128'h8000_0000_0000_0000_0000_0000_0000_0001));
    wait_done();
    @(negedge clk);

    for (int j = 0; j < 4; j++) begin
      logic [63:0] p;
      logic [127:0] k;
      p = {32'(j * 32'h9e37_79b9), 32'(~j)};
      k = {4{32'(j * 32'h85eb_ca6b + 1)}};
      encrypt(p, k, model(p, k));
      wait_done();
      @(negedge clk);
    end

    repeat (4) @(negedge clk);
    check(q.size() == 0, "R2 all results seen", 64'(q.size()), 64'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule